// File: doc/BRIEF.md
# Per-Instruction Stride Learning Table

This block watches a stream of load accesses and learns, separately for each load instruction, the distance between consecutive addresses that instruction touches. Each access presents the instruction address (PC), the data address, a secure-world flag and a requester number. The table is set-associative. The set is picked by a folded XOR hash of the PC. Each entry keeps the last address, the learned stride and a small saturating confidence counter.

A lookup that matches an entry measures the new stride. It then moves confidence up or down. The stored stride is replaced only once confidence has fallen below the threshold. A lookup that finds no match claims a way picked by a free-running LFSR. One cycle after each accepted access, the block reports three things: whether the access hit, the stride it measured, and whether the entry is now confident enough to drive prefetching.

A downstream address generator uses these results. An option gives each requester a private bank of the table.

Top module: `pc_stride_table`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low, so the first access from any PC misses.
- R2: An access with `req_valid` high and `req_pc_valid` low produces no response and changes no entry.
- R3: The set index is `((pc>>1) ^ ((pc>>1)>>log2(SETS))) & (SETS-1)`. Three PCs whose bits [3:1] agree but whose hashed sets differ can all stay resident in a 2-way table at the same time.
- R4: A hit needs a valid entry in the indexed set whose stored PC and stored secure flag both equal the request. All ways of that set are searched.
- R5: On a hit, `rsp_stride` is the current address minus the stored last address (modulo 2^ADDR_W). The stored last address then becomes the current address.
- R6: On a hit whose measured stride equals the stored stride and is nonzero, confidence rises by one, up to MAX_CONF. `rsp_confident` is high when the updated confidence is at least THRESH_CONF.
- R7: On a hit whose measured stride is zero or differs from the stored one, confidence falls by one, down to MIN_CONF. The stored stride is replaced by the measured stride only if the updated confidence is below THRESH_CONF.
- R8: On a miss, a way chosen by the free-running LFSR is written with the PC, the address, the secure flag, a stride of 0 and START_CONF. The response then reports hit 0, stride 0 and not confident.
- R9: When PER_ID_BANKS is 1, `req_id` selects a private bank, so the same PC trained by one requester misses for another. When PER_ID_BANKS is 0, bank 0 is always used.
- R10: The response is registered and appears exactly one cycle after the accepted access. Back-to-back accesses each see the updates made by the ones before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_pc_valid | input | 1 | Access carries a usable PC |
| req_pc | input | PC_W | Instruction address of the load |
| req_addr | input | ADDR_W | Data address of the load |
| req_secure | input | 1 | Secure-world flag of the access |
| req_id | input | ID_W | Requester number |
| rsp_valid | output | 1 | Result of the previous cycle's access |
| rsp_hit | output | 1 | Access matched an entry |
| rsp_stride | output | ADDR_W | Measured stride (0 on a miss) |
| rsp_confident | output | 1 | Updated confidence at or above threshold |

## Verification
The bench trains one PC up to saturation, breaks its stride while confidence is still high, and then feeds it repeated zero strides until confidence is pinned at the minimum. A design that retrained the stride too early, or counted a zero stride as a match, would report the wrong stride or the wrong confidence flag on the hits that follow. An access without a PC is placed between two trained accesses. If that access left any trace, the stride measured next would be wrong.

Three PCs that share their low PC bits are cycled round after round. An index taken without the XOR fold would squeeze them into one two-way set and force misses. The same PC is also presented with the other secure flag and from another requester; a design that ignored either field would report a false hit.

// File: rtl/stp_pkg.sv
package stp_pkg;

   // Kind of table write performed for an accepted access.
   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_TRAIN = 2'd1,
      WR_ALLOC = 2'd2
   } wr_kind_e;

   // Ceiling log2 that never returns less than one bit.
   function automatic int min1_clog2(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/stp_set_hash.sv
module stp_set_hash #(
   parameter int PC_W = 32,
   parameter int SETS = 8,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic [PC_W-1:0]  pc,
   output logic [SET_W-1:0] set_idx
);
   logic [PC_W-1:0] half_pc;
   logic [PC_W-1:0] folded;

   assign half_pc = pc >> 1;
   assign folded  = half_pc >> SET_W;
   assign set_idx = SET_W'((half_pc ^ folded) & PC_W'(SETS - 1));
endmodule

// File: rtl/stp_lfsr.sv
module stp_lfsr #(
   parameter int          LFSR_W = 16,
   parameter logic [31:0] SEED   = 32'h0000_ACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [LFSR_W-1:0] state
);
   logic fb;

   generate
      if (LFSR_W == 8) begin : g_w8
         assign fb = state[7] ^ state[5] ^ state[4] ^ state[3];
      end else if (LFSR_W == 16) begin : g_w16
         assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];
      end else if (LFSR_W == 32) begin : g_w32
         assign fb = state[31] ^ state[21] ^ state[1] ^ state[0];
      end else begin : g_bad
         $error("stp_lfsr: LFSR_W must be 8, 16 or 32");
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= (LFSR_W'(SEED) == '0) ? LFSR_W'(1) : LFSR_W'(SEED);
      end else begin
         state <= {state[LFSR_W-2:0], fb};
      end
   end
endmodule

// File: rtl/stp_train.sv
module stp_train #(
   parameter int ADDR_W     = 32,
   parameter int CONF_W     = 3,
   parameter int MAX_CONF   = 7,
   parameter int MIN_CONF   = 0,
   parameter int THRESH_CONF = 4
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ADDR_W-1:0] old_last,
   input  logic [ADDR_W-1:0] old_stride,
   input  logic [CONF_W-1:0] old_conf,
   output logic [ADDR_W-1:0] seen_stride,
   output logic [ADDR_W-1:0] next_stride,
   output logic [CONF_W-1:0] next_conf,
   output logic              confident
);
   logic same_step;

   assign seen_stride = cur_addr - old_last;
   assign same_step   = (seen_stride == old_stride) && (seen_stride != '0);

   always_comb begin
      next_conf   = old_conf;
      next_stride = old_stride;
      if (same_step) begin
         if (old_conf < CONF_W'(MAX_CONF)) next_conf = old_conf + 1'b1;
      end else begin
         if (old_conf > CONF_W'(MIN_CONF)) next_conf = old_conf - 1'b1;
         if (next_conf < CONF_W'(THRESH_CONF)) next_stride = seen_stride;
      end
   end

   assign confident = (next_conf >= CONF_W'(THRESH_CONF));
endmodule

// File: rtl/pc_stride_table.sv
module pc_stride_table
   import stp_pkg::*;
#(
   parameter int PC_W         = 32,
   parameter int ADDR_W       = 32,
   parameter int ID_W         = 1,
   parameter int SETS         = 8,
   parameter int WAYS         = 2,
   parameter bit PER_ID_BANKS = 1'b1,
   parameter int CONF_W       = 3,
   parameter int MAX_CONF     = 7,
   parameter int MIN_CONF     = 0,
   parameter int THRESH_CONF  = 4,
   parameter int START_CONF   = 4,
   parameter int LFSR_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_pc_valid,
   input  logic [PC_W-1:0]   req_pc,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_secure,
   input  logic [ID_W-1:0]   req_id,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [ADDR_W-1:0] rsp_stride,
   output logic              rsp_confident
);
   localparam int BANKS  = PER_ID_BANKS ? (1 << ID_W) : 1;
   localparam int BANK_W = min1_clog2(BANKS);
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = min1_clog2(WAYS);

   // Elaboration checks on the parameter set.
   generate
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_chk_sets
         $error("pc_stride_table: SETS must be a power of two, at least 2");
      end
      if (WAYS < 1) begin : g_chk_ways
         $error("pc_stride_table: WAYS must be at least 1");
      end
      if (MAX_CONF >= (1 << CONF_W) || MIN_CONF > MAX_CONF) begin : g_chk_conf
         $error("pc_stride_table: confidence bounds do not fit CONF_W");
      end
      if (START_CONF < MIN_CONF || START_CONF > MAX_CONF ||
          THRESH_CONF < MIN_CONF || THRESH_CONF > MAX_CONF) begin : g_chk_start
         $error("pc_stride_table: start or threshold outside confidence range");
      end
      if (LFSR_W < WAY_W) begin : g_chk_lfsr
         $error("pc_stride_table: LFSR narrower than way index");
      end
   endgenerate

   // Entry storage.
   logic              vld_q  [BANKS][SETS][WAYS];
   logic              sec_q  [BANKS][SETS][WAYS];
   logic [PC_W-1:0]   pc_q   [BANKS][SETS][WAYS];
   logic [ADDR_W-1:0] last_q [BANKS][SETS][WAYS];
   logic [ADDR_W-1:0] step_q [BANKS][SETS][WAYS];
   logic [CONF_W-1:0] conf_q [BANKS][SETS][WAYS];

   // Bank selection.
   logic [BANK_W-1:0] bank;
   generate
      if (PER_ID_BANKS) begin : g_bank_by_id
         assign bank = BANK_W'(req_id);
      end else begin : g_bank_zero
         assign bank = '0;
      end
   endgenerate

   // Set index from the folded PC hash.
   logic [SET_W-1:0] set_idx;
   stp_set_hash #(.PC_W(PC_W), .SETS(SETS)) u_hash (
      .pc      (req_pc),
      .set_idx (set_idx)
   );

   // Random victim way.
   logic [LFSR_W-1:0] lfsr_state;
   logic [WAY_W-1:0]  victim_way;
   stp_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (lfsr_state)
   );

   generate
      if (WAYS == 1) begin : g_one_way
         assign victim_way = '0;
      end else begin : g_many_way
         assign victim_way = WAY_W'(lfsr_state % LFSR_W'(WAYS));
      end
   endgenerate

   // Search all ways of the selected set.
   logic             hit;
   logic [WAY_W-1:0] hit_way;
   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!hit && vld_q[bank][set_idx][w] &&
             pc_q[bank][set_idx][w] == req_pc &&
             sec_q[bank][set_idx][w] == req_secure) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end

   // Training arithmetic on the matched entry.
   logic [ADDR_W-1:0] seen_stride;
   logic [ADDR_W-1:0] next_stride;
   logic [CONF_W-1:0] next_conf;
   logic              confident;

   stp_train #(
      .ADDR_W      (ADDR_W),
      .CONF_W      (CONF_W),
      .MAX_CONF    (MAX_CONF),
      .MIN_CONF    (MIN_CONF),
      .THRESH_CONF (THRESH_CONF)
   ) u_train (
      .cur_addr    (req_addr),
      .old_last    (last_q[bank][set_idx][hit_way]),
      .old_stride  (step_q[bank][set_idx][hit_way]),
      .old_conf    (conf_q[bank][set_idx][hit_way]),
      .seen_stride (seen_stride),
      .next_stride (next_stride),
      .next_conf   (next_conf),
      .confident   (confident)
   );

   // Decide the kind of write.
   wr_kind_e wr_kind;
   always_comb begin
      if (!(req_valid && req_pc_valid)) wr_kind = WR_NONE;
      else if (hit)                     wr_kind = WR_TRAIN;
      else                              wr_kind = WR_ALLOC;
   end

   // Single-cycle read-modify-write of the table.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < BANKS; b++) begin
            for (int s = 0; s < SETS; s++) begin
               for (int w = 0; w < WAYS; w++) begin
                  vld_q[b][s][w]  <= 1'b0;
                  sec_q[b][s][w]  <= 1'b0;
                  pc_q[b][s][w]   <= '0;
                  last_q[b][s][w] <= '0;
                  step_q[b][s][w] <= '0;
                  conf_q[b][s][w] <= '0;
               end
            end
         end
      end else begin
         case (wr_kind)
            WR_TRAIN: begin
               last_q[bank][set_idx][hit_way] <= req_addr;
               step_q[bank][set_idx][hit_way] <= next_stride;
               conf_q[bank][set_idx][hit_way] <= next_conf;
            end
            WR_ALLOC: begin
               vld_q[bank][set_idx][victim_way]  <= 1'b1;
               sec_q[bank][set_idx][victim_way]  <= req_secure;
               pc_q[bank][set_idx][victim_way]   <= req_pc;
               last_q[bank][set_idx][victim_way] <= req_addr;
               step_q[bank][set_idx][victim_way] <= '0;
               conf_q[bank][set_idx][victim_way] <= CONF_W'(START_CONF);
            end
            default: ;
         endcase
      end
   end

   // Registered response.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_stride    <= '0;
         rsp_confident <= 1'b0;
      end else begin
         rsp_valid     <= (wr_kind != WR_NONE);
         rsp_hit       <= (wr_kind == WR_TRAIN);
         rsp_stride    <= (wr_kind == WR_TRAIN) ? seen_stride : '0;
         rsp_confident <= (wr_kind == WR_TRAIN) && confident;
      end
   end
endmodule

// File: rtl/stp_checker.sv
module stp_checker #(
   parameter int ADDR_W = 32,
   parameter int LFSR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_pc_valid,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [ADDR_W-1:0] rsp_stride,
   input logic              rsp_confident,
   input logic [LFSR_W-1:0] lfsr_state
);
   // R10: a response only ever follows an accepted access.
   p_rsp_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_pc_valid));

   // R2: an access without a PC leaves no response behind.
   p_nopc_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_pc_valid) |=> !rsp_valid);

   // R8: a miss reports a zero stride and no confidence.
   p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_stride == '0 && !rsp_confident));

   // R8: the victim generator never locks up at zero.
   p_lfsr_alive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);

   // R10: with no response, the result flags stay low.
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_confident));
endmodule

bind pc_stride_table stp_checker #(.ADDR_W(ADDR_W), .LFSR_W(LFSR_W)) u_stp_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_pc_valid  (req_pc_valid),
   .rsp_valid     (rsp_valid),
   .rsp_hit       (rsp_hit),
   .rsp_stride    (rsp_stride),
   .rsp_confident (rsp_confident),
   .lfsr_state    (lfsr_state)
);

// File: tb/pc_stride_table_bench.sv
module pc_stride_table_bench;
   localparam int THR  = 4;
   localparam int MAXC = 7;
   localparam int MINC = 0;
   localparam int STC  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_pc_valid = 1'b0;
   logic [31:0] req_pc = '0;
   logic [31:0] req_addr = '0;
   logic        req_secure = 1'b0;
   logic [0:0]  req_id = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [31:0] rsp_stride;
   logic        rsp_confident;

   always #10 clk = ~clk;

   pc_stride_table #(
      .PC_W(32), .ADDR_W(32), .ID_W(1), .SETS(8), .WAYS(2), .PER_ID_BANKS(1'b1),
      .CONF_W(3), .MAX_CONF(MAXC), .MIN_CONF(MINC), .THRESH_CONF(THR),
      .START_CONF(STC), .LFSR_W(16)
   ) u_pc_stride_table (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc_valid(req_pc_valid),
      .req_pc(req_pc), .req_addr(req_addr), .req_secure(req_secure), .req_id(req_id),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_stride(rsp_stride),
      .rsp_confident(rsp_confident)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic        hit;
      logic [31:0] stride;
      logic        conf;
   } exp_t;
   exp_t  exp_q[$];
   string tag_q[$];

   // Reference model: one record per (pc, secure, bank) key.
   logic [31:0] m_pc[64];
   logic        m_sec[64];
   logic        m_bank[64];
   logic [31:0] m_last[64];
   logic [31:0] m_step[64];
   int          m_conf[64];
   int          m_n = 0;

   task automatic send(input logic [31:0] pc, input logic [31:0] addr,
                       input logic sec, input logic id, input string tag);
      int   idx = -1;
      exp_t e;
      for (int i = 0; i < m_n; i++)
         if (m_pc[i] == pc && m_sec[i] == sec && m_bank[i] == id) idx = i;
      if (idx < 0) begin
         m_pc[m_n] = pc; m_sec[m_n] = sec; m_bank[m_n] = id;
         m_last[m_n] = addr; m_step[m_n] = '0; m_conf[m_n] = STC;
         m_n++;
         e = '{hit: 1'b0, stride: 32'h0, conf: 1'b0};
      end else begin
         logic [31:0] d;
         d = addr - m_last[idx];
         if (d == m_step[idx] && d != 0) begin
            if (m_conf[idx] < MAXC) m_conf[idx]++;
         end else begin
            if (m_conf[idx] > MINC) m_conf[idx]--;
            if (m_conf[idx] < THR) m_step[idx] = d;
         end
         m_last[idx] = addr;
         e = '{hit: 1'b1, stride: d, conf: (m_conf[idx] >= THR)};
      end
      @(negedge clk);
      req_valid = 1'b1; req_pc_valid = 1'b1; req_pc = pc; req_addr = addr;
      req_secure = sec; req_id = id;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_pc_valid = 1'b0;
   endtask

   // R2: an access without a PC; its response slot must stay empty.
   task automatic send_nopc(input logic [31:0] pc, input logic [31:0] addr);
      @(negedge clk);
      req_valid = 1'b1; req_pc_valid = 1'b0; req_pc = pc; req_addr = addr;
      req_secure = 1'b0; req_id = '0;
      @(negedge clk);
      req_valid = 1'b0;
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R2 access without PC: rsp_valid actual %b expected 0", rsp_valid);
      end
   endtask

   // Monitor: compare each response with the head of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && !done && rsp_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R10 response with no pending access: actual valid 1 expected 0");
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rsp_hit !== e.hit || rsp_stride !== e.stride || rsp_confident !== e.conf) begin
               errors++;
               $display("FAIL %s: actual hit %b stride %h conf %b expected hit %b stride %h conf %b",
                        t, rsp_hit, rsp_stride, rsp_confident, e.hit, e.stride, e.conf);
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: rsp_valid actual %b expected 0", rsp_valid);
      end
      rst_n = 1'b1;

      // PC 0x40 (set 4): train upward, saturate, break, then zero strides.
      send(32'h40, 32'h1000, 1'b0, 1'b0, "R1 R8 first access misses");
      send(32'h40, 32'h1040, 1'b0, 1'b0, "R7 R5 retrain below threshold");
      send(32'h40, 32'h1080, 1'b0, 1'b0, "R6 reaches threshold");
      send(32'h40, 32'h10C0, 1'b0, 1'b0, "R6 confidence rises");
      send(32'h40, 32'h1100, 1'b0, 1'b0, "R6 confidence rises");
      send(32'h40, 32'h1140, 1'b0, 1'b0, "R6 confidence at max");
      send(32'h40, 32'h1180, 1'b0, 1'b0, "R6 confidence saturates");
      send(32'h40, 32'h9000, 1'b0, 1'b0, "R7 mismatch keeps stride above threshold");
      send(32'h40, 32'h9040, 1'b0, 1'b0, "R7 old stride still matches");
      for (int k = 0; k < 8; k++)
         send(32'h40, 32'h9040, 1'b0, 1'b0, "R7 zero stride decrements to min");
      send(32'h40, 32'h9080, 1'b0, 1'b0, "R7 retrain at min confidence");
      send_nopc(32'h40, 32'h5555_0000);
      send(32'h40, 32'h90C0, 1'b0, 1'b0, "R2 ignored access left entry untouched");

      // PC 0x80 (set 0): negative stride.
      send(32'h80, 32'h8000, 1'b0, 1'b0, "R8 miss on new PC");
      send(32'h80, 32'h7FC0, 1'b0, 1'b0, "R5 negative stride measured");
      send(32'h80, 32'h7F80, 1'b0, 1'b0, "R6 negative stride gains confidence");
      send(32'h80, 32'h7F40, 1'b0, 1'b0, "R6 negative stride stays confident");

      // PC 0xE0 (set 6): the secure flag is part of the match.
      send(32'hE0, 32'h3000, 1'b0, 1'b0, "R8 miss before secure test");
      send(32'hE0, 32'h3010, 1'b0, 1'b0, "R4 same PC same secure hits");
      send(32'hE0, 32'h3020, 1'b1, 1'b0, "R4 secure mismatch misses");

      // PC 0x10E (set 7): private bank per requester.
      send(32'h10E, 32'h4000, 1'b0, 1'b0, "R9 miss requester 0");
      send(32'h10E, 32'h4100, 1'b0, 1'b0, "R9 hit requester 0");
      send(32'h10E, 32'h4200, 1'b0, 1'b1, "R9 other requester misses");
      send(32'h10E, 32'h4300, 1'b0, 1'b0, "R9 requester 0 entry survives");

      // PCs 0x10, 0x20, 0x30: bits [3:1] equal, hashed sets 1, 2, 3.
      for (int r = 0; r < 4; r++)
         for (int p = 1; p <= 3; p++)
            send(32'(p * 16), 32'h6000 + 32'(p * 32'h1000) + 32'(r * 32'h20),
                 1'b0, 1'b0, "R3 folded hash keeps all three resident");

      idle();
      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R10 responses missing: actual %0d pending expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule